// File: doc/BRIEF.md
# Multi-mode host bus interface

This block connects an 8-bit internal register file to an external host over one of three bus styles. Two static select inputs pick the style. The first style is a plain bus with a 5-bit address, an 8-bit data bus and separate active-low read and write commands. The second style multiplexes address and data on one 8-bit bus, uses an address strobe, and keeps the active-low read and write commands. The third style uses the same multiplexed bus, but one pin gives the direction and the other pin is an active-low data strobe. On the register side the block gives a single-cycle read pulse and a single-cycle write pulse, each with an 8-bit register address.

The pin set is shared between functions according to the style. In the multiplexed styles the two low address pins become general-purpose I/O bits, and the three high address pins become bank selects that form the top of the register address. The active-low chip select stands for a 32-byte block decode in the plain style and a 256-byte page decode in the multiplexed styles. The data bus is given as separate in, out and enable signals, because the pad buffers lie outside the block.

Two open-drain indications are available to the register side. The first can stretch the current cycle and the second can announce that a shortened cycle is allowed. Each one only acts when the register side enables it.

All host inputs are taken to be synchronous to `clk`.

Top module: `hostBusBridge`

## Requirements
- R1: `hostSel` picks the bus style. 2'b01 is multiplexed with read/write commands, 2'b10 is multiplexed with direction and data strobe, and 2'b00 and the reserved 2'b11 both behave as the plain 5-bit-address style.
- R2: In the plain style the register address is {3'b000, addrHi[2:0], addrLoIn[1:0]}. It is sampled on the clock edge where a qualified command is first seen low. A write reaches the register side as one `regWrEn` pulse in the cycle after `wrN` is seen high again. The pulse carries the data sampled on the last clock edge while `wrN` was low.
- R3: In both multiplexed styles, every clock edge with `astrb` high loads `busIn[4:0]` into an address latch, and `busIn[7:5]` is ignored. The register address is {addrHi[2:0], latch[4:0]}.
- R4: In style 2'b10, pin `wrN` is an active-low data strobe and pin `rdN` gives the direction, with 1 = read and 0 = write. A write requires `rdN` low when the strobe falls, and the write commits when the strobe rises.
- R5: A read or write starts only if `csN` is low and `aen` is low when the command is first seen. An unqualified command produces no `regRdEn`, no `regWrEn` and no drive on the data bus.
- R6: `busOe` rises on the clock edge after the edge where a qualified read start was seen, and falls on the edge after the read command is seen released. While `busOe` is high, `busOut` holds the register value returned in the single `regRdEn` cycle. At all other times `busOe` is low.
- R7: In the multiplexed styles, `gpioIn` follows `addrLoIn`, `addrLoOe` follows `gpioOe`, and `bankSel` follows `addrHi`. In the plain style, `gpioIn`, `addrLoOe` and `bankSel` are all zero.
- R8: `rdyPullLow` is high only while a bus cycle is active and both `stretchEn` and `stretchReq` are high. `noWsPullLow` follows the same rule with `noWaitEn` and `noWaitReq`.
- R9: While `rst` is high, the address latch is cleared, any cycle in progress is abandoned, and `busOe` is low on the following edge. After reset, a multiplexed read with no address strobe uses latch value 0.
- R10: In the styles with separate commands, if `rdN` and `wrN` are both low at the start, the cycle is a read and no write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| hostSel | input | 2 | Static bus style select |
| csN | input | 1 | Active-low chip select (block or page decode) |
| aen | input | 1 | Active-high address enable; blocks register access when high |
| rdN | input | 1 | Read command, or direction line in style 2'b10 |
| wrN | input | 1 | Write command, or data strobe in style 2'b10 |
| astrb | input | 1 | Address strobe for the multiplexed styles |
| addrHi | input | 3 | Address bits 4:2, or bank selects |
| addrLoIn | input | 2 | Address bits 1:0, or GPIO pin input |
| addrLoOut | output | 2 | GPIO pin output value |
| addrLoOe | output | 2 | GPIO pin output enable |
| busIn | input | 8 | Data or multiplexed address/data from the pads |
| busOut | output | 8 | Read data to the pads |
| busOe | output | 1 | Data bus drive enable |
| gpioOut | input | 2 | GPIO bits 4:3 output value from the register side |
| gpioOe | input | 2 | GPIO bits 4:3 direction from the register side |
| gpioIn | output | 2 | GPIO bits 4:3 pin state to the register side |
| bankSel | output | 3 | Bank selects seen in the multiplexed styles |
| regAddr | output | 8 | Register address |
| regRdEn | output | 1 | Single-cycle register read request |
| regRdData | input | 8 | Register read data, valid in the `regRdEn` cycle |
| regWrEn | output | 1 | Single-cycle register write request |
| regWrData | output | 8 | Register write data |
| stretchEn | input | 1 | Enables cycle stretching |
| stretchReq | input | 1 | Requests cycle stretching |
| noWaitEn | input | 1 | Enables the shortened-cycle indication |
| noWaitReq | input | 1 | Requests the shortened-cycle indication |
| rdyPullLow | output | 1 | Pull the ready line low |
| noWsPullLow | output | 1 | Pull the no-wait-state line low |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 5-bit block address and 3 bank bits. With these values the whole 256-entry register space can be swept in each multiplexed style, and the 32-entry block can be swept in both plain-style encodings. Each address is written with an arithmetic pattern specific to its style and then read back. Random-looking upper bits on the address phase show that those bits are ignored. The bench also covers the following cases:
- accesses blocked by `aen` or `csN`;
- both commands low together;
- a reset in the middle of a read, followed by a read with no address phase;
- the gating of the pin-sharing outputs and the open-drain outputs.

// File: rtl/hbbPkg.sv
package hbbPkg;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_MUXCMD = 2'd1,
    MODE_MUXRNW = 2'd2
  } busMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } cycState_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic latchAddr;   // load the multiplexed address latch
    logic startCmd;    // capture the live address for this cycle
    logic captureWr;   // sample write data from the bus
    logic captureRd;   // sample register read data
    logic driveOn;     // start driving the data bus
    logic driveOff;    // stop driving the data bus
  } dpStrobe_t;

  function automatic busMode_e decodeMode(input logic [1:0] sel);
    case (sel)
      2'b01:   decodeMode = MODE_MUXCMD;
      2'b10:   decodeMode = MODE_MUXRNW;
      default: decodeMode = MODE_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/hbbCtrl.sv
module hbbCtrl
  import hbbPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] hostSel,
  input  logic      csN,
  input  logic      aen,
  input  logic      rdN,
  input  logic      wrN,
  input  logic      astrb,
  input  logic      stretchEn,
  input  logic      stretchReq,
  input  logic      noWaitEn,
  input  logic      noWaitReq,
  output dpStrobe_t strobes,
  output logic      isMux,
  output logic      regRdEn,
  output logic      regWrEn,
  output logic      rdyPullLow,
  output logic      noWsPullLow
);

  busMode_e  mode;
  cycState_e state, stateNext;
  logic      rnwMode;
  logic      qualified;
  logic      readReq, writeReq;
  logic      rdStart, wrStart;
  logic      rdHold, wrHold;
  logic      commit;
  logic      cycleActive;

  assign mode    = decodeMode(hostSel);
  assign isMux   = (mode != MODE_PLAIN);
  assign rnwMode = (mode == MODE_MUXRNW);

  // Access only when selected and not during a DMA-owned bus phase
  assign qualified = !csN && !aen;

  // Command decode per style; a read wins if both commands are low
  always_comb begin
    if (rnwMode) begin
      readReq  = !wrN &&  rdN;
      writeReq = !wrN && !rdN;
      rdHold   = !wrN;
    end else begin
      readReq  = !rdN;
      writeReq = !wrN && rdN;
      rdHold   = !rdN;
    end
  end

  assign wrHold  = !wrN;
  assign rdStart = (state == ST_IDLE) && qualified && readReq;
  assign wrStart = (state == ST_IDLE) && qualified && writeReq;
  assign commit  = (state == ST_WRITE) && !wrHold;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (rdStart)      stateNext = ST_READ;
        else if (wrStart) stateNext = ST_WRITE;
      end
      ST_READ:  if (!rdHold) stateNext = ST_IDLE;
      ST_WRITE: if (!wrHold) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobes.latchAddr = isMux && astrb;
    strobes.startCmd  = rdStart || wrStart;
    strobes.captureWr = wrStart || ((state == ST_WRITE) && wrHold);
    strobes.captureRd = rdStart;
    strobes.driveOn   = rdStart;
    strobes.driveOff  = (state == ST_READ) && !rdHold;
  end

  assign regRdEn = rdStart;
  assign regWrEn = commit;

  assign cycleActive = (state != ST_IDLE) || rdStart || wrStart;
  assign rdyPullLow  = cycleActive && stretchEn && stretchReq;
  assign noWsPullLow = cycleActive && noWaitEn && noWaitReq;

endmodule

// File: rtl/hbbDatapath.sv
module hbbDatapath
  import hbbPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ISA_ADDR_W = 5,
  parameter int BANK_W     = 3,
  localparam int LO_W       = ISA_ADDR_W - BANK_W,
  localparam int REG_ADDR_W = BANK_W + ISA_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             strobes,
  input  logic                  isMux,
  input  logic [BANK_W-1:0]     addrHi,
  input  logic [LO_W-1:0]       addrLoIn,
  input  logic [DATA_W-1:0]     busIn,
  input  logic [DATA_W-1:0]     regRdData,
  input  logic [LO_W-1:0]       gpioOut,
  input  logic [LO_W-1:0]       gpioOe,
  output logic [DATA_W-1:0]     busOut,
  output logic                  busOe,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     regWrData,
  output logic [LO_W-1:0]       gpioIn,
  output logic [LO_W-1:0]       addrLoOut,
  output logic [LO_W-1:0]       addrLoOe,
  output logic [BANK_W-1:0]     bankSel
);

  logic [ISA_ADDR_W-1:0] addrLatch;
  logic [REG_ADDR_W-1:0] cmdAddr;
  logic [REG_ADDR_W-1:0] liveAddr;
  logic [DATA_W-1:0]     wrData;
  logic [DATA_W-1:0]     rdData;
  logic                  oe;

  // Address as seen at the pins in the current style
  assign liveAddr = isMux ? {addrHi, addrLatch}
                          : {{BANK_W{1'b0}}, addrHi, addrLoIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      addrLatch <= '0;
      cmdAddr   <= '0;
      oe        <= 1'b0;
    end else begin
      if (strobes.latchAddr) addrLatch <= busIn[ISA_ADDR_W-1:0];
      if (strobes.startCmd)  cmdAddr   <= liveAddr;
      if (strobes.driveOn)       oe <= 1'b1;
      else if (strobes.driveOff) oe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.captureWr) wrData <= busIn;
    if (strobes.captureRd) rdData <= regRdData;
  end

  assign regAddr   = strobes.startCmd ? liveAddr : cmdAddr;
  assign regWrData = wrData;
  assign busOut    = rdData;
  assign busOe     = oe;

  // Pin sharing: low address pins become GPIO, high pins bank selects
  generate
    for (genvar i = 0; i < LO_W; i++) begin : gLoPin
      assign gpioIn[i]    = isMux && addrLoIn[i];
      assign addrLoOe[i]  = isMux && gpioOe[i];
      assign addrLoOut[i] = gpioOut[i];
    end
  endgenerate

  assign bankSel = isMux ? addrHi : '0;

endmodule

// File: rtl/hostBusBridge.sv
module hostBusBridge
  import hbbPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ISA_ADDR_W = 5,
  parameter int BANK_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   hostSel,
  input  logic                         csN,
  input  logic                         aen,
  input  logic                         rdN,
  input  logic                         wrN,
  input  logic                         astrb,
  input  logic [BANK_W-1:0]            addrHi,
  input  logic [ISA_ADDR_W-BANK_W-1:0] addrLoIn,
  output logic [ISA_ADDR_W-BANK_W-1:0] addrLoOut,
  output logic [ISA_ADDR_W-BANK_W-1:0] addrLoOe,
  input  logic [DATA_W-1:0]            busIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  input  logic [ISA_ADDR_W-BANK_W-1:0] gpioOut,
  input  logic [ISA_ADDR_W-BANK_W-1:0] gpioOe,
  output logic [ISA_ADDR_W-BANK_W-1:0] gpioIn,
  output logic [BANK_W-1:0]            bankSel,
  output logic [BANK_W+ISA_ADDR_W-1:0] regAddr,
  output logic                         regRdEn,
  input  logic [DATA_W-1:0]            regRdData,
  output logic                         regWrEn,
  output logic [DATA_W-1:0]            regWrData,
  input  logic                         stretchEn,
  input  logic                         stretchReq,
  input  logic                         noWaitEn,
  input  logic                         noWaitReq,
  output logic                         rdyPullLow,
  output logic                         noWsPullLow
);

  dpStrobe_t strobes;
  logic      isMux;

  hbbCtrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .hostSel     (hostSel),
    .csN         (csN),
    .aen         (aen),
    .rdN         (rdN),
    .wrN         (wrN),
    .astrb       (astrb),
    .stretchEn   (stretchEn),
    .stretchReq  (stretchReq),
    .noWaitEn    (noWaitEn),
    .noWaitReq   (noWaitReq),
    .strobes     (strobes),
    .isMux       (isMux),
    .regRdEn     (regRdEn),
    .regWrEn     (regWrEn),
    .rdyPullLow  (rdyPullLow),
    .noWsPullLow (noWsPullLow)
  );

  hbbDatapath #(
    .DATA_W     (DATA_W),
    .ISA_ADDR_W (ISA_ADDR_W),
    .BANK_W     (BANK_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .isMux     (isMux),
    .addrHi    (addrHi),
    .addrLoIn  (addrLoIn),
    .busIn     (busIn),
    .regRdData (regRdData),
    .gpioOut   (gpioOut),
    .gpioOe    (gpioOe),
    .busOut    (busOut),
    .busOe     (busOe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .gpioIn    (gpioIn),
    .addrLoOut (addrLoOut),
    .addrLoOe  (addrLoOe),
    .bankSel   (bankSel)
  );

endmodule

// File: rtl/hbbChecker.sv
module hbbChecker #(
  parameter int ISA_ADDR_W = 5,
  parameter int BANK_W     = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic [1:0]                   hostSel,
  input logic                         csN,
  input logic                         aen,
  input logic                         busOe,
  input logic                         regRdEn,
  input logic                         regWrEn,
  input logic [ISA_ADDR_W-BANK_W-1:0] addrLoOe,
  input logic [BANK_W-1:0]            bankSel,
  input logic                         stretchEn,
  input logic                         stretchReq,
  input logic                         noWaitEn,
  input logic                         noWaitReq,
  input logic                         rdyPullLow,
  input logic                         noWsPullLow
);

  logic rstSeenQ;
  always_ff @(posedge clk) rstSeenQ <= rst;

  // R6: the bus is only taken after a register read request
  a_r6_drive_follows_read: assert property (@(posedge clk) disable iff (rst)
    $rose(busOe) |-> $past(regRdEn));

  // R6: never drive while a write commits
  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> !busOe);

  // R2: one commit pulse per write
  a_r2_single_commit: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn);

  // R5: reads start only when selected and address enable is low
  a_r5_qualified_read: assert property (@(posedge clk) disable iff (rst)
    regRdEn |-> (!csN && !aen));

  // R7: plain style keeps shared pins quiet
  a_r7_plain_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    (hostSel == 2'b00 || hostSel == 2'b11) |-> (addrLoOe == '0 && bankSel == '0));

  // R8: open-drain indications gated by their enables
  a_r8_stretch_gated: assert property (@(posedge clk) disable iff (rst)
    rdyPullLow |-> (stretchEn && stretchReq));

  a_r8_nowait_gated: assert property (@(posedge clk) disable iff (rst)
    noWsPullLow |-> (noWaitEn && noWaitReq));

  // R9: the edge after reset leaves the bus released and no write pending
  always @(posedge clk) begin
    if (rstSeenQ) begin
      a_r9_reset_quiet: assert (!busOe && !regWrEn)
        else $error("R9 bus or write active after reset");
    end
  end

endmodule

bind hostBusBridge hbbChecker #(
  .ISA_ADDR_W (ISA_ADDR_W),
  .BANK_W     (BANK_W)
) u_hbbChecker (
  .clk         (clk),
  .rst         (rst),
  .hostSel     (hostSel),
  .csN         (csN),
  .aen         (aen),
  .busOe       (busOe),
  .regRdEn     (regRdEn),
  .regWrEn     (regWrEn),
  .addrLoOe    (addrLoOe),
  .bankSel     (bankSel),
  .stretchEn   (stretchEn),
  .stretchReq  (stretchReq),
  .noWaitEn    (noWaitEn),
  .noWaitReq   (noWaitReq),
  .rdyPullLow  (rdyPullLow),
  .noWsPullLow (noWsPullLow)
);

// File: tb/tb_hostBusBridge.sv
`timescale 1ns/1ps
module tb_hostBusBridge;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] hostSel;
  logic       csN, aen, rdN, wrN, astrb;
  logic [2:0] addrHi;
  logic [1:0] addrLoIn, addrLoOut, addrLoOe;
  logic [7:0] busIn, busOut;
  logic       busOe;
  logic [1:0] gpioOut, gpioOe, gpioIn;
  logic [2:0] bankSel;
  logic [7:0] regAddr, regRdData, regWrData;
  logic       regRdEn, regWrEn;
  logic       stretchEn, stretchReq, noWaitEn, noWaitReq;
  logic       rdyPullLow, noWsPullLow;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  hostBusBridge dut (
    .clk(clk), .rst(rst), .hostSel(hostSel), .csN(csN), .aen(aen),
    .rdN(rdN), .wrN(wrN), .astrb(astrb), .addrHi(addrHi),
    .addrLoIn(addrLoIn), .addrLoOut(addrLoOut), .addrLoOe(addrLoOe),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .gpioIn(gpioIn), .bankSel(bankSel),
    .regAddr(regAddr), .regRdEn(regRdEn), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .stretchEn(stretchEn), .stretchReq(stretchReq),
    .noWaitEn(noWaitEn), .noWaitReq(noWaitReq),
    .rdyPullLow(rdyPullLow), .noWsPullLow(noWsPullLow)
  );

  // Simple register file model on the internal side
  logic [7:0] regMem [256];
  initial for (int i = 0; i < 256; i++) regMem[i] = 8'h00;
  always @(posedge clk) if (regWrEn) regMem[regAddr] <= regWrData;
  assign regRdData = regMem[regAddr];

  function automatic logic [7:0] patPlain(input int a);  return 8'((a * 7) + 3); endfunction
  function automatic logic [7:0] patCmd(input int a);    return 8'(a) ^ 8'h5A;   endfunction
  function automatic logic [7:0] patRnw(input int a);    return 8'((a * 3) + 1); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] sel);
    @(negedge clk);
    hostSel = sel; rst = 1'b1;
    csN = 1'b1; aen = 1'b0; rdN = 1'b1; wrN = 1'b1; astrb = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit isMuxSel(input logic [1:0] sel);
    return (sel == 2'b01) || (sel == 2'b10);
  endfunction

  // Address phase: pins in plain style, strobe-latched bus in multiplexed styles
  task automatic addrPhase(input int a, input logic [2:0] junk);
    if (isMuxSel(hostSel)) begin
      addrHi = 3'(a >> 5);
      busIn  = {junk, 5'(a)};
      astrb  = 1'b1;
      @(negedge clk);
      astrb  = 1'b0;
      busIn  = 8'h00;
    end else begin
      addrHi   = 3'(a >> 2);
      addrLoIn = 2'(a);
    end
  endtask

  task automatic busWrite(input logic [7:0] d, input logic aenV, input logic csV);
    busIn = d; csN = csV; aen = aenV;
    if (hostSel == 2'b10) rdN = 1'b0;
    wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1; aen = 1'b0; busIn = 8'h00;
  endtask

  task automatic busRead(input logic [7:0] exp, input string tag);
    csN = 1'b0;
    if (hostSel == 2'b10) begin rdN = 1'b1; wrN = 1'b0; end
    else rdN = 1'b0;
    @(negedge clk);
    chk({tag, " R6 oe during read"}, busOe, 1'b1);
    chk(tag, busOut, exp);
    rdN = 1'b1; wrN = 1'b1;
    @(negedge clk);
    chk({tag, " R6 oe released"}, busOe, 1'b0);
    csN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hostSel = 2'b00; csN = 1'b1; aen = 1'b0; rdN = 1'b1; wrN = 1'b1;
    astrb = 1'b0; addrHi = 3'd0; addrLoIn = 2'd0; busIn = 8'h00;
    gpioOut = 2'b00; gpioOe = 2'b00;
    stretchEn = 1'b0; stretchReq = 1'b0; noWaitEn = 1'b0; noWaitReq = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset busOe", busOe, 1'b0);
    chk("R9 reset regWrEn", regWrEn, 1'b0);
    chk("R9 reset regRdEn", regRdEn, 1'b0);
    doReset(2'b00);

    // R1 R2 plain style sweep
    for (int a = 0; a < 32; a++) begin addrPhase(a, 3'd0); busWrite(patPlain(a), 1'b0, 1'b0); end
    for (int a = 0; a < 32; a++) begin addrPhase(a, 3'd0); busRead(patPlain(a), "R2 plain readback"); end

    // R7 plain style pin sharing quiet
    addrLoIn = 2'b11; addrHi = 3'b101; gpioOe = 2'b11; #1;
    chk("R7 plain gpioIn", gpioIn, 2'b00);
    chk("R7 plain addrLoOe", addrLoOe, 2'b00);
    chk("R7 plain bankSel", bankSel, 3'b000);
    gpioOe = 2'b00;

    // R5 blocked by aen and by chip select
    addrPhase(5, 3'd0); busWrite(8'hC3, 1'b1, 1'b0);
    addrPhase(5, 3'd0); busWrite(8'h3C, 1'b0, 1'b1);
    addrPhase(5, 3'd0); busRead(patPlain(5), "R5 blocked write left value");
    addrPhase(6, 3'd0); csN = 1'b1; rdN = 1'b0; #1;
    chk("R5 no read pulse unselected", regRdEn, 1'b0);
    @(negedge clk);
    chk("R5 no drive unselected", busOe, 1'b0);
    rdN = 1'b1;
    @(negedge clk);

    // R10 both commands low: read wins
    addrPhase(3, 3'd0);
    busIn = 8'hEE; csN = 1'b0; rdN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    chk("R10 read taken", busOe, 1'b1);
    chk("R10 read data", busOut, patPlain(3));
    rdN = 1'b1; wrN = 1'b1;
    @(negedge clk);
    csN = 1'b1;
    addrPhase(3, 3'd0); busRead(patPlain(3), "R10 no write committed");

    // R8 open-drain indications
    addrPhase(1, 3'd0);
    stretchEn = 1'b1; stretchReq = 1'b1; noWaitReq = 1'b1; #1;
    chk("R8 idle no stretch", rdyPullLow, 1'b0);
    csN = 1'b0; rdN = 1'b0; #1;
    chk("R8 stretch in cycle", rdyPullLow, 1'b1);
    chk("R8 nowait disabled", noWsPullLow, 1'b0);
    noWaitEn = 1'b1; #1;
    chk("R8 nowait enabled", noWsPullLow, 1'b1);
    stretchEn = 1'b0; #1;
    chk("R8 stretch disabled", rdyPullLow, 1'b0);
    @(negedge clk);
    rdN = 1'b1;
    @(negedge clk);
    csN = 1'b1; stretchReq = 1'b0; noWaitEn = 1'b0; noWaitReq = 1'b0;

    // R1 reserved encoding behaves as plain style
    doReset(2'b11);
    for (int a = 0; a < 32; a++) begin addrPhase(a, 3'd0); busRead(patPlain(a), "R1 reserved as plain"); end

    // R3 multiplexed with commands: full page sweep, upper bus bits junk
    doReset(2'b01);
    for (int a = 0; a < 256; a++) begin addrPhase(a, 3'(a * 5)); busWrite(patCmd(a), 1'b0, 1'b0); end
    for (int a = 0; a < 256; a++) begin addrPhase(a, 3'(a + 2)); busRead(patCmd(a), "R3 mux cmd readback"); end

    // R7 multiplexed pin sharing
    addrLoIn = 2'b10; addrHi = 3'b011; gpioOe = 2'b01; gpioOut = 2'b11; #1;
    chk("R7 mux gpioIn", gpioIn, 2'b10);
    chk("R7 mux addrLoOe", addrLoOe, 2'b01);
    chk("R7 mux addrLoOut", addrLoOut, 2'b11);
    chk("R7 mux bankSel", bankSel, 3'b011);
    gpioOe = 2'b00; gpioOut = 2'b00;

    // R4 multiplexed with direction and data strobe
    doReset(2'b10);
    for (int a = 0; a < 256; a++) begin addrPhase(a, 3'(a * 3)); busWrite(patRnw(a), 1'b0, 1'b0); end
    for (int a = 0; a < 256; a++) begin addrPhase(a, 3'(a)); busRead(patRnw(a), "R4 rnw readback"); end

    // R9 reset during a read, then a read with no address phase
    addrPhase(8'h47, 3'd0);
    csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    chk("R9 read active before reset", busOe, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 bus released by reset", busOe, 1'b0);
    rst = 1'b0; wrN = 1'b1; csN = 1'b1;
    @(negedge clk);
    addrHi = 3'd2;
    busRead(patRnw(8'h40), "R9 latch cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule